// File: doc/BRIEF.md
# Top-Level Trap Control Register Unit

This block holds the 64-bit trap-control register that belongs to the most privileged exception level, EL3. It also decides whether an access from a lower level is sent to EL3 for handling. Software at EL3 reaches the register through a system-register access port. The port carries the five encoding fields, a read/write flag, the current exception level and the write data. An access from any level below EL3 is refused with an undefined-instruction flag.

The rest of the core asks the trap-query port about one access at a time. It supplies the kind of access, the exception level that issued it, and whether a lower-level control already traps it. The block answers in the same cycle with a trap-to-EL3 decision, taken from the current register contents.

Three build-time parameters include or remove the activity-monitor, vector-extension and trace-register controls. A control that is removed becomes a reserved bit.

Top module: `trap_ctl_unit`

## Requirements
- R1: Every bit other than 31, 30, 20, 10 and 8 reads as zero, and writes to those bits have no effect. The read value is `sr_rdata`.
- R2: The register is selected only when `sr_valid` is 1 and the fields are op0=2'b11, op1=3'b110, CRn=4'b0001, CRm=4'b0001, op2=3'b010. Any other encoding leaves `sr_undef` at 0 and `sr_rdata` at 0, and it does not modify the register.
- R3: A selected access with `sr_el` of 0, 1 or 2 sets `sr_undef` to 1 in the same cycle and returns `sr_rdata` = 0. A write made this way leaves the register unchanged.
- R4: A selected read at EL3 (`sr_el`=3, `sr_write`=0) returns the register on `sr_rdata` in the same cycle. A selected write at EL3 loads the writable bits from `sr_wdata` at the next rising clock edge.
- R5: After reset the register reads as all zeros.
- R6: Bit 31 is the control-register trap. With bit 31 set and `q_low_trap`=0, two kinds of access are trapped. Class 1 (access to the EL2 trap register) traps from EL2 only. Class 2 (access to the EL1 access-control register) traps from EL1 or EL2. Neither class traps when `q_low_trap` is 1.
- R7: Bit 30 is the activity-monitor trap. With bit 30 set, class 3 traps from EL0, EL1 and EL2, but not from EL3. `q_low_trap` has no effect on this class.
- R8: Bit 20 is the trace-register trap. With bit 20 set and `q_low_trap`=0, class 4 traps from every exception level.
- R9: Bit 10 is the floating-point/SIMD trap. With bit 10 set, class 5 and class 6 trap from every exception level.
- R10: Bit 8 has inverted polarity. With bit 8 clear, class 6 (vector-extension access) traps from every level. With bit 8 set, class 6 traps only through bit 10.
- R11: When a feature parameter is 0, its bit is reserved: it reads 0, ignores writes and never causes a trap. Bit 30 belongs to `HAS_MON`, bit 8 to `HAS_VEC` and bit 20 to `HAS_TRC`. With `HAS_VEC`=0, class 6 traps only through bit 10.
- R12: `q_trap` depends combinationally on the current register and the query inputs. A write in the same cycle affects it only after the clock edge. Classes 0 and 7 never trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_valid | input | 1 | A system-register access is presented |
| sr_write | input | 1 | 1 = write, 0 = read |
| sr_op0 | input | 2 | Encoding field op0 |
| sr_op1 | input | 3 | Encoding field op1 |
| sr_crn | input | 4 | Encoding field CRn |
| sr_crm | input | 4 | Encoding field CRm |
| sr_op2 | input | 3 | Encoding field op2 |
| sr_el | input | 2 | Current exception level of the access |
| sr_wdata | input | 64 | Write data |
| sr_rdata | output | 64 | Read data, zero unless a legal read hits |
| sr_undef | output | 1 | Access is undefined at this level |
| q_class | input | 3 | Class of the queried access |
| q_el | input | 2 | Exception level that issued the queried access |
| q_low_trap | input | 1 | A lower-level control already traps this access |
| q_trap | output | 1 | Trap the queried access to EL3 |

## Verification
The register write and the trap query can fall in the same cycle. The question then is whether the decision uses the old register value or the new one. The bench presents an EL3 write together with a query whose answer differs between the two values. It then expects the old answer before the clock edge and the new answer after it. Besides this case, the bench sweeps all 32 settings of the five control bits against every query class, exception level and lower-trap flag. It runs the sweep on a full-featured instance and on a featureless instance driven by the same inputs.

// File: rtl/trap_ctl_pkg.sv
package trap_ctl_pkg;

    localparam int REG_W   = 64;
    localparam int CLS_W   = 3;
    localparam int EL_W    = 2;

    // bit positions of the controls (architecturally fixed)
    localparam int BIT_CTL = 31;
    localparam int BIT_MON = 30;
    localparam int BIT_TRC = 20;
    localparam int BIT_FPU = 10;
    localparam int BIT_VEC = 8;

    localparam logic [EL_W-1:0] EL_TOP = 2'd3;

    typedef enum logic [CLS_W-1:0] {
        CLS_NONE   = 3'd0,
        CLS_EL2REG = 3'd1,
        CLS_EL1REG = 3'd2,
        CLS_MON    = 3'd3,
        CLS_TRC    = 3'd4,
        CLS_FPU    = 3'd5,
        CLS_VEC    = 3'd6,
        CLS_RSVD   = 3'd7
    } acc_cls_e;

    typedef struct packed {
        logic ctl_reg;
        logic mon;
        logic trc;
        logic fpu;
        logic vec_en;
    } ctl_t;

    function automatic logic [REG_W-1:0] ctl_pack(input ctl_t c);
        logic [REG_W-1:0] v;
        v          = '0;
        v[BIT_CTL] = c.ctl_reg;
        v[BIT_MON] = c.mon;
        v[BIT_TRC] = c.trc;
        v[BIT_FPU] = c.fpu;
        v[BIT_VEC] = c.vec_en;
        return v;
    endfunction

endpackage

// File: rtl/trap_ctl_decode.sv
module trap_ctl_decode
    import trap_ctl_pkg::*;
(
    input  logic            sr_valid,
    input  logic            sr_write,
    input  logic [1:0]      sr_op0,
    input  logic [2:0]      sr_op1,
    input  logic [3:0]      sr_crn,
    input  logic [3:0]      sr_crm,
    input  logic [2:0]      sr_op2,
    input  logic [EL_W-1:0] sr_el,
    output logic            rd_en,
    output logic            wr_en,
    output logic            undef
);
    logic hit;
    logic legal;

    always_comb begin
        hit   = sr_valid && (sr_op0 == 2'b11) && (sr_op1 == 3'b110) &&
                (sr_crn == 4'b0001) && (sr_crm == 4'b0001) && (sr_op2 == 3'b010);
        legal = (sr_el == EL_TOP);
        rd_en = hit && legal && !sr_write;
        wr_en = hit && legal && sr_write;
        undef = hit && !legal;
    end
endmodule

// File: rtl/trap_ctl_store.sv
module trap_ctl_store
    import trap_ctl_pkg::*;
#(
    parameter bit HAS_MON = 1'b1,
    parameter bit HAS_VEC = 1'b1,
    parameter bit HAS_TRC = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             undef,
    input  logic [REG_W-1:0] wdata,
    output ctl_t             ctl_q
);
    typedef struct packed {
        ctl_t ctl;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctl.ctl_reg = wdata[BIT_CTL];
            st_d.ctl.mon     = HAS_MON ? wdata[BIT_MON] : 1'b0;
            st_d.ctl.trc     = HAS_TRC ? wdata[BIT_TRC] : 1'b0;
            st_d.ctl.fpu     = wdata[BIT_FPU];
            st_d.ctl.vec_en  = HAS_VEC ? wdata[BIT_VEC] : 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl_q = st_q.ctl;

    // R3: a refused access never alters the register
    p_undef_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        undef |=> $stable(st_q));

    // R4: a legal write loads the fixed bits from the data
    p_write_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_q.ctl.ctl_reg == $past(wdata[BIT_CTL])) &&
                  (st_q.ctl.fpu == $past(wdata[BIT_FPU])));

    // R11: absent features stay zero
    p_absent_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (HAS_MON || !st_q.ctl.mon) && (HAS_VEC || !st_q.ctl.vec_en) &&
                 (HAS_TRC || !st_q.ctl.trc));
endmodule

// File: rtl/trap_ctl_judge.sv
module trap_ctl_judge
    import trap_ctl_pkg::*;
#(
    parameter bit HAS_MON = 1'b1,
    parameter bit HAS_VEC = 1'b1,
    parameter bit HAS_TRC = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctl_t             ctl,
    input  logic [CLS_W-1:0] q_class,
    input  logic [EL_W-1:0]  q_el,
    input  logic             q_low_trap,
    output logic             q_trap
);
    logic below_top;
    logic vec_block;

    always_comb begin
        below_top = (q_el != EL_TOP);
        vec_block = HAS_VEC && !ctl.vec_en;
        unique case (acc_cls_e'(q_class))
            CLS_EL2REG: q_trap = ctl.ctl_reg && (q_el == 2'd2) && !q_low_trap;
            CLS_EL1REG: q_trap = ctl.ctl_reg && ((q_el == 2'd1) || (q_el == 2'd2)) && !q_low_trap;
            CLS_MON:    q_trap = HAS_MON && ctl.mon && below_top;
            CLS_TRC:    q_trap = HAS_TRC && ctl.trc && !q_low_trap;
            CLS_FPU:    q_trap = ctl.fpu;
            CLS_VEC:    q_trap = vec_block || ctl.fpu;
            default:    q_trap = 1'b0;
        endcase
    end

    // R12: unused classes never trap
    p_none_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((q_class == CLS_NONE) || (q_class == CLS_RSVD)) |-> !q_trap);

    // R6: lower-level trap takes the access
    p_defer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q_low_trap && ((q_class == CLS_EL2REG) || (q_class == CLS_EL1REG))) |-> !q_trap);

    // R7: EL3 itself is never trapped by the monitor control
    p_mon_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((q_class == CLS_MON) && (q_el == EL_TOP)) |-> !q_trap);

    // R10: a clear vector enable always traps vector use
    p_vec_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_VEC && (q_class == CLS_VEC) && !ctl.vec_en) |-> q_trap);
endmodule

// File: rtl/trap_ctl_unit.sv
module trap_ctl_unit
    import trap_ctl_pkg::*;
#(
    parameter bit HAS_MON = 1'b1,
    parameter bit HAS_VEC = 1'b1,
    parameter bit HAS_TRC = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sr_valid,
    input  logic        sr_write,
    input  logic [1:0]  sr_op0,
    input  logic [2:0]  sr_op1,
    input  logic [3:0]  sr_crn,
    input  logic [3:0]  sr_crm,
    input  logic [2:0]  sr_op2,
    input  logic [1:0]  sr_el,
    input  logic [63:0] sr_wdata,
    output logic [63:0] sr_rdata,
    output logic        sr_undef,
    input  logic [2:0]  q_class,
    input  logic [1:0]  q_el,
    input  logic        q_low_trap,
    output logic        q_trap
);
    localparam logic [REG_W-1:0] WR_MASK = ctl_pack('{ctl_reg: 1'b1, mon: HAS_MON,
                                                      trc: HAS_TRC, fpu: 1'b1,
                                                      vec_en: HAS_VEC});

    logic rd_en, wr_en;
    ctl_t ctl_q;

    trap_ctl_decode u_dec (
        .sr_valid (sr_valid), .sr_write (sr_write),
        .sr_op0   (sr_op0),   .sr_op1   (sr_op1),
        .sr_crn   (sr_crn),   .sr_crm   (sr_crm),
        .sr_op2   (sr_op2),   .sr_el    (sr_el),
        .rd_en    (rd_en),    .wr_en    (wr_en),
        .undef    (sr_undef)
    );

    trap_ctl_store #(.HAS_MON(HAS_MON), .HAS_VEC(HAS_VEC), .HAS_TRC(HAS_TRC)) u_st (
        .clk   (clk),   .rst_n (rst_n),
        .wr_en (wr_en), .undef (sr_undef),
        .wdata (sr_wdata & WR_MASK),
        .ctl_q (ctl_q)
    );

    trap_ctl_judge #(.HAS_MON(HAS_MON), .HAS_VEC(HAS_VEC), .HAS_TRC(HAS_TRC)) u_jd (
        .clk        (clk),     .rst_n      (rst_n),
        .ctl        (ctl_q),
        .q_class    (q_class), .q_el       (q_el),
        .q_low_trap (q_low_trap),
        .q_trap     (q_trap)
    );

    assign sr_rdata = rd_en ? ctl_pack(ctl_q) : '0;

    // R1: reserved positions never read back as one
    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_rdata & ~WR_MASK) == '0);

    // R3: a refused access returns no data
    p_undef_no_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sr_undef |-> (sr_rdata == '0));
endmodule

// File: tb/sim_trap_ctl_unit.sv
module sim_trap_ctl_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sr_valid = 1'b0, sr_write = 1'b0;
    logic [1:0]  sr_op0 = 2'b11;
    logic [2:0]  sr_op1 = 3'b110;
    logic [3:0]  sr_crn = 4'b0001, sr_crm = 4'b0001;
    logic [2:0]  sr_op2 = 3'b010;
    logic [1:0]  sr_el = 2'd3;
    logic [63:0] sr_wdata = '0;
    logic [2:0]  q_class = 3'd0;
    logic [1:0]  q_el = 2'd0;
    logic        q_low_trap = 1'b0;
    logic [63:0] rd0, rd1;
    logic        un0, un1, tr0, tr1;

    int n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    trap_ctl_unit u0 (
        .clk(clk), .rst_n(rst_n), .sr_valid(sr_valid), .sr_write(sr_write),
        .sr_op0(sr_op0), .sr_op1(sr_op1), .sr_crn(sr_crn), .sr_crm(sr_crm),
        .sr_op2(sr_op2), .sr_el(sr_el), .sr_wdata(sr_wdata),
        .sr_rdata(rd0), .sr_undef(un0),
        .q_class(q_class), .q_el(q_el), .q_low_trap(q_low_trap), .q_trap(tr0));

    trap_ctl_unit #(.HAS_MON(1'b0), .HAS_VEC(1'b0), .HAS_TRC(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .sr_valid(sr_valid), .sr_write(sr_write),
        .sr_op0(sr_op0), .sr_op1(sr_op1), .sr_crn(sr_crn), .sr_crm(sr_crm),
        .sr_op2(sr_op2), .sr_el(sr_el), .sr_wdata(sr_wdata),
        .sr_rdata(rd1), .sr_undef(un1),
        .q_class(q_class), .q_el(q_el), .q_low_trap(q_low_trap), .q_trap(tr1));

    // five control bits c[4:0] = {b31, b30, b20, b10, b8}
    function automatic logic [63:0] spread(input logic [4:0] c);
        return (64'(c[4]) << 31) | (64'(c[3]) << 30) | (64'(c[2]) << 20) |
               (64'(c[1]) << 10) | (64'(c[0]) << 8);
    endfunction

    function automatic logic [4:0] keep(input logic [4:0] c, input bit full);
        return full ? c : (c & 5'b10010);
    endfunction

    function automatic logic exp_trap(input logic [4:0] c, input bit full,
                                      input int cls, input int el, input bit low);
        case (cls)
            1: return c[4] && el == 2 && !low;
            2: return c[4] && (el == 1 || el == 2) && !low;
            3: return full && c[3] && el != 3;
            4: return full && c[2] && !low;
            5: return c[1];
            6: return c[1] || (full && !c[0]);
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [1:0] el, input logic [63:0] d,
                          input bit good_enc);
        @(negedge clk);
        sr_valid = 1'b1; sr_write = wr; sr_el = el; sr_wdata = d;
        sr_op2 = good_enc ? 3'b010 : 3'b011;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        sr_valid = 1'b0; sr_write = 1'b0; sr_op2 = 3'b010; sr_el = 2'd3;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R5: reset value
        access(1'b0, 2'd3, '0, 1'b1);
        chk(rd0 == '0, "R5 reset u0", rd0, '0);
        chk(rd1 == '0, "R5 reset u1", rd1, '0);
        idle();

        for (int c = 0; c < 32; c++) begin
            logic [4:0] cv = 5'(c);
            // R1: reserved bits written as ones
            access(1'b1, 2'd3, spread(cv) | ~spread(5'h1f), 1'b1);
            idle();
            // R4 readback
            access(1'b0, 2'd3, '0, 1'b1);
            chk(rd0 == spread(cv), "R1 R4 readback u0", rd0, spread(cv));
            chk(rd1 == spread(keep(cv, 1'b0)), "R11 readback u1", rd1, spread(keep(cv, 1'b0)));
            idle();
            for (int k = 0; k < 8; k++)
                for (int e = 0; e < 4; e++)
                    for (int l = 0; l < 2; l++) begin
                        logic x0, x1;
                        q_class = 3'(k); q_el = 2'(e); q_low_trap = l[0];
                        #1;
                        x0 = exp_trap(cv, 1'b1, k, e, l[0]);
                        x1 = exp_trap(keep(cv, 1'b0), 1'b0, k, e, l[0]);
                        // R6 R7 R8 R9 R10 R12 on u0, R11 on u1
                        chk(tr0 == x0, "R6-class trap u0 (R7 R8 R9 R10 R12)", 64'(tr0), 64'(x0));
                        chk(tr1 == x1, "R11 trap u1", 64'(tr1), 64'(x1));
                    end
        end

        // R3: lower levels refused, no change
        access(1'b1, 2'd3, spread(5'b10101), 1'b1);
        idle();
        for (int e = 0; e < 3; e++) begin
            access(1'b0, 2'(e), '0, 1'b1);
            chk(un0 == 1'b1, "R3 undef on read", 64'(un0), 64'd1);
            chk(rd0 == '0, "R3 read data zero", rd0, '0);
            idle();
            access(1'b1, 2'(e), '1, 1'b1);
            chk(un0 == 1'b1, "R3 undef on write", 64'(un0), 64'd1);
            idle();
            access(1'b0, 2'd3, '0, 1'b1);
            chk(rd0 == spread(5'b10101), "R3 value unchanged", rd0, spread(5'b10101));
            chk(un0 == 1'b0, "R4 EL3 not undef", 64'(un0), 64'd0);
            idle();
        end

        // R2: other encoding is inert at any level
        for (int e = 0; e < 4; e++) begin
            access(1'b1, 2'(e), '1, 1'b0);
            chk(un0 == 1'b0, "R2 no undef off-encoding", 64'(un0), 64'd0);
            chk(rd0 == '0, "R2 no data off-encoding", rd0, '0);
            idle();
        end
        access(1'b0, 2'd3, '0, 1'b1);
        chk(rd0 == spread(5'b10101), "R2 value unchanged", rd0, spread(5'b10101));
        idle();

        // R12: write and query in the same cycle
        q_class = 3'd5; q_el = 2'd0; q_low_trap = 1'b0;
        access(1'b1, 2'd3, spread(5'b00010), 1'b1);
        chk(tr0 == 1'b0, "R12 old value before edge", 64'(tr0), 64'd0);
        @(posedge clk); #1;
        chk(tr0 == 1'b1, "R12 new value after edge", 64'(tr0), 64'd1);
        idle();

        summary();
    end
endmodule